// File: doc/BRIEF.md
# Speculative Micro-op Execution Gate

This block sits between the issue stage and the execution and memory units and decides what happens to micro-ops that belong to a predicted branch path. A path is opened only when the predictor's confidence for it is strictly greater than a configurable threshold. While the path is open, any micro-op marked with the speculation tag is screened by its class. Arithmetic and other harmless work passes through. Loads pass only when the data cache already holds the line. Stores are held back. Loads that miss and operations that could trap are parked.

When the branch resolves, the held work either becomes architectural or disappears. On a taken resolution, the parked micro-ops are replayed to the execution port and the held stores are released to the memory port. Both go one per cycle, in the order they arrived, and the two streams run side by side. On a not-taken resolution, every held store and parked micro-op is discarded and its slot becomes free at once. Results that were let through speculatively carry a flag on the output, so downstream logic can tell them apart.

Only one speculative path can be open at a time. Backpressure on the issue handshake covers a full store buffer, a full park queue, the resolve cycle and the drain that follows a commit.

Top module: `spec_gate`

## Requirements
- R1: A path opens (`spec_active` goes high one cycle after a `spec_req` pulse) only when `pred_prob > cfg_thr`, compared unsigned. Otherwise the request is ignored.
- R2: A micro-op accepted while no path is open, or accepted with `in_spec`=0, appears on the execution port in the next cycle with its class and ID and with `out_spec`=0. With no path open, `in_spec` has no effect.
- R3: A speculative store (class 2) produces nothing on either output port until its path commits.
- R4: A speculative load (class 1) is forwarded in the next cycle with `out_spec`=1 when `in_hit`=1. When `in_hit`=0 it is parked and produces no output.
- R5: A speculative may-fault micro-op (class 3) is parked and produces no output. A speculative other micro-op (class 0) is forwarded in the next cycle with `out_spec`=1.
- R6: After a taken resolution, parked micro-ops leave the execution port with `out_replay`=1 and `out_spec`=0. They come out in arrival order, one per consecutive cycle, starting in the second cycle after the resolve edge.
- R7: After a taken resolution, held stores leave on `st_valid`/`st_id` in arrival order, one per consecutive cycle. They start in the same cycle as the first replay.
- R8: A not-taken resolution closes the path and discards all held stores and parked micro-ops. None of them ever appears on an output, and the full capacity of both buffers is available for the next path.
- R9: When the store buffer holds SB_DEPTH entries, a speculative store sees `in_ready`=0, while micro-ops of other classes are still accepted.
- R10: When the park queue holds RQ_DEPTH entries, a micro-op that would be parked sees `in_ready`=0.
- R11: `in_ready` is 0 in the resolve cycle and for the whole drain after a commit. It returns to 1 once both buffers are empty.
- R12: After reset, `spec_active`, `out_valid` and `st_valid` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_thr | input | PW | Confidence threshold for opening a path |
| spec_req | input | 1 | Predictor requests a speculative path |
| pred_prob | input | PW | Predicted taken confidence for the request |
| res_valid | input | 1 | Branch resolution strobe |
| res_taken | input | 1 | 1 = commit the path, 0 = squash it |
| in_valid | input | 1 | Issue micro-op valid |
| in_ready | output | 1 | Gate accepts the micro-op |
| in_spec | input | 1 | Micro-op belongs to the open path |
| in_cls | input | 2 | Class: 0 other, 1 load, 2 store, 3 may-fault |
| in_id | input | IDW | Destination ID |
| in_hit | input | 1 | Data cache hit indication for a load |
| out_valid | output | 1 | Execution port valid |
| out_cls | output | 2 | Class of forwarded micro-op |
| out_id | output | IDW | ID of forwarded micro-op |
| out_spec | output | 1 | Forwarded result is still speculative |
| out_replay | output | 1 | Micro-op is a replay after commit |
| st_valid | output | 1 | Released store valid |
| st_id | output | IDW | ID of released store |
| spec_active | output | 1 | A speculative path is open |

## Verification
The bench builds the gate with a 3-bit confidence width and 4-entry buffers. At that size every threshold and confidence pair (64 pairs) can be swept against the open rule, and both buffers can be filled to capacity within a few issues. Class mixes cover every forward, hold and park path, including the repeated-miss case. Commit and squash are each checked by comparing the logged output streams, including cycle stamps, against orders and latencies worked out in the bench.

// File: rtl/spec_gate_pkg.sv
`timescale 1ns/1ps
package spec_gate_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_FAULT = 2'd3
  } uop_cls_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPEC  = 2'd1,
    ST_DRAIN = 2'd2
  } gate_state_t;
endpackage

// File: rtl/spec_gate_fifo.sv
`timescale 1ns/1ps
// Ordered holding queue with a single-cycle flush; storage has no reset.
module spec_gate_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/spec_gate_ctrl.sv
`timescale 1ns/1ps
// Path state: closed, open, or draining after a commit.
module spec_gate_ctrl
  import spec_gate_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spec_req,
  input  logic [PW-1:0] pred_prob,
  input  logic [PW-1:0] cfg_thr,
  input  logic          res_valid,
  input  logic          res_taken,
  input  logic          bufs_empty,
  output gate_state_t   state
);
  gate_state_t nxt_state;

  always_comb begin
    nxt_state = state;
    unique case (state)
      ST_IDLE:  if (spec_req && (pred_prob > cfg_thr)) nxt_state = ST_SPEC;
      ST_SPEC:  if (res_valid) nxt_state = res_taken ? ST_DRAIN : ST_IDLE;
      ST_DRAIN: if (bufs_empty) nxt_state = ST_IDLE;
      default:  nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt_state;
  end
endmodule

// File: rtl/spec_gate_admit.sv
`timescale 1ns/1ps
// Classifies an incoming micro-op against the open path and the buffer fill.
module spec_gate_admit
  import spec_gate_pkg::*;
(
  input  gate_state_t state,
  input  logic        res_valid,
  input  logic        in_valid,
  input  logic        in_spec,
  input  logic [1:0]  in_cls,
  input  logic        in_hit,
  input  logic        sb_full,
  input  logic        rq_full,
  output logic        in_ready,
  output logic        is_spec,
  output logic        sb_push,
  output logic        rq_push,
  output logic        pass
);
  uop_cls_t cls;
  logic     want_sb, want_rq, acc;

  always_comb begin
    cls      = uop_cls_t'(in_cls);
    is_spec  = in_spec && (state == ST_SPEC);
    want_sb  = is_spec && (cls == CLS_STORE);
    want_rq  = is_spec && ((cls == CLS_FAULT) || ((cls == CLS_LOAD) && !in_hit));
    in_ready = (state != ST_DRAIN)
            && !((state == ST_SPEC) && res_valid)
            && !(want_sb && sb_full)
            && !(want_rq && rq_full);
    acc      = in_valid && in_ready;
    sb_push  = acc && want_sb;
    rq_push  = acc && want_rq;
    pass     = acc && !want_sb && !want_rq;
  end
endmodule

// File: rtl/spec_gate.sv
`timescale 1ns/1ps
module spec_gate
  import spec_gate_pkg::*;
#(
  parameter int PW       = 8,
  parameter int IDW      = 6,
  parameter int SB_DEPTH = 8,
  parameter int RQ_DEPTH = 8,
  localparam int SBCW    = $clog2(SB_DEPTH + 1),
  localparam int RQCW    = $clog2(RQ_DEPTH + 1),
  localparam int RQW     = IDW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PW-1:0]  cfg_thr,
  input  logic           spec_req,
  input  logic [PW-1:0]  pred_prob,
  input  logic           res_valid,
  input  logic           res_taken,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_spec,
  input  logic [1:0]     in_cls,
  input  logic [IDW-1:0] in_id,
  input  logic           in_hit,
  output logic           out_valid,
  output logic [1:0]     out_cls,
  output logic [IDW-1:0] out_id,
  output logic           out_spec,
  output logic           out_replay,
  output logic           st_valid,
  output logic [IDW-1:0] st_id,
  output logic           spec_active
);
  gate_state_t     state_q;
  logic            is_spec, sb_push, rq_push, pass;
  logic            sb_full, sb_empty, rq_full, rq_empty;
  logic [SBCW-1:0] sb_cnt;
  logic [RQCW-1:0] rq_cnt;
  logic [IDW-1:0]  sb_rdata;
  logic [RQW-1:0]  rq_rdata;
  logic            squash, draining, sb_pop, rq_pop;

  assign squash      = (state_q == ST_SPEC) && res_valid && !res_taken;
  assign draining    = (state_q == ST_DRAIN);
  assign sb_pop      = draining && !sb_empty;
  assign rq_pop      = draining && !rq_empty;
  assign spec_active = (state_q == ST_SPEC);

  spec_gate_ctrl #(.PW(PW)) u_ctrl (
    .clk(clk), .rst(rst), .spec_req(spec_req), .pred_prob(pred_prob),
    .cfg_thr(cfg_thr), .res_valid(res_valid), .res_taken(res_taken),
    .bufs_empty(sb_empty && rq_empty), .state(state_q)
  );

  spec_gate_admit u_admit (
    .state(state_q), .res_valid(res_valid), .in_valid(in_valid),
    .in_spec(in_spec), .in_cls(in_cls), .in_hit(in_hit),
    .sb_full(sb_full), .rq_full(rq_full), .in_ready(in_ready),
    .is_spec(is_spec), .sb_push(sb_push), .rq_push(rq_push), .pass(pass)
  );

  spec_gate_fifo #(.W(IDW), .DEPTH(SB_DEPTH)) u_store_buf (
    .clk(clk), .rst(rst), .flush(squash), .push(sb_push), .wdata(in_id),
    .pop(sb_pop), .rdata(sb_rdata), .full(sb_full), .empty(sb_empty),
    .count(sb_cnt)
  );

  spec_gate_fifo #(.W(RQW), .DEPTH(RQ_DEPTH)) u_park_q (
    .clk(clk), .rst(rst), .flush(squash), .push(rq_push),
    .wdata({in_cls, in_id}), .pop(rq_pop), .rdata(rq_rdata),
    .full(rq_full), .empty(rq_empty), .count(rq_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_replay <= 1'b0;
      out_spec   <= 1'b0;
      out_cls    <= '0;
      out_id     <= '0;
      st_valid   <= 1'b0;
      st_id      <= '0;
    end else begin
      out_valid  <= pass || rq_pop;
      out_replay <= rq_pop;
      out_spec   <= pass && is_spec;
      out_cls    <= rq_pop ? rq_rdata[IDW +: 2] : in_cls;
      out_id     <= rq_pop ? rq_rdata[IDW-1:0] : in_id;
      st_valid   <= sb_pop;
      st_id      <= sb_rdata;
    end
  end
endmodule

// File: rtl/spec_gate_sva.sv
`timescale 1ns/1ps
module spec_gate_sva
  import spec_gate_pkg::*;
#(
  parameter int PW       = 8,
  parameter int SB_DEPTH = 8,
  parameter int RQ_DEPTH = 8,
  localparam int SBCW    = $clog2(SB_DEPTH + 1),
  localparam int RQCW    = $clog2(RQ_DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            spec_req,
  input logic [PW-1:0]   pred_prob,
  input logic [PW-1:0]   cfg_thr,
  input logic            spec_active,
  input logic            res_valid,
  input logic            res_taken,
  input logic            in_ready,
  input logic            st_valid,
  input logic            out_replay,
  input gate_state_t     state_q,
  input logic [SBCW-1:0] sb_cnt,
  input logic [RQCW-1:0] rq_cnt
);
  p_enter_above_thr_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(spec_active) |-> $past(spec_req && (pred_prob > cfg_thr)));

  p_store_held_r3: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> $past(state_q == ST_DRAIN));

  p_replay_after_commit_r6: assert property (@(posedge clk) disable iff (rst)
    out_replay |-> $past(state_q == ST_DRAIN));

  p_squash_frees_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SPEC && res_valid && !res_taken)
      |=> (sb_cnt == '0 && rq_cnt == '0 && !spec_active));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    sb_cnt <= SBCW'(SB_DEPTH));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    rq_cnt <= RQCW'(RQ_DEPTH));

  p_drain_stall_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN) |-> !in_ready);
endmodule

bind spec_gate spec_gate_sva #(.PW(PW), .SB_DEPTH(SB_DEPTH), .RQ_DEPTH(RQ_DEPTH)) u_sva (
  .clk(clk), .rst(rst), .spec_req(spec_req), .pred_prob(pred_prob),
  .cfg_thr(cfg_thr), .spec_active(spec_active), .res_valid(res_valid),
  .res_taken(res_taken), .in_ready(in_ready), .st_valid(st_valid),
  .out_replay(out_replay), .state_q(state_q), .sb_cnt(sb_cnt), .rq_cnt(rq_cnt)
);

// File: tb/spec_gate_bench.sv
`timescale 1ns/1ps
module spec_gate_bench;
  localparam int PW = 3, IDW = 4, SBD = 4, RQD = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [PW-1:0] cfg_thr = '0, pred_prob = '0;
  logic spec_req = 0, res_valid = 0, res_taken = 0;
  logic in_valid = 0, in_spec = 0, in_hit = 0;
  logic [1:0] in_cls = '0;
  logic [IDW-1:0] in_id = '0;
  logic in_ready, out_valid, out_spec, out_replay, st_valid, spec_active;
  logic [1:0] out_cls;
  logic [IDW-1:0] out_id, st_id;

  always #4 clk = ~clk;

  spec_gate #(.PW(PW), .IDW(IDW), .SB_DEPTH(SBD), .RQ_DEPTH(RQD)) u_spec_gate (
    .clk(clk), .rst(rst), .cfg_thr(cfg_thr), .spec_req(spec_req),
    .pred_prob(pred_prob), .res_valid(res_valid), .res_taken(res_taken),
    .in_valid(in_valid), .in_ready(in_ready), .in_spec(in_spec),
    .in_cls(in_cls), .in_id(in_id), .in_hit(in_hit), .out_valid(out_valid),
    .out_cls(out_cls), .out_id(out_id), .out_spec(out_spec),
    .out_replay(out_replay), .st_valid(st_valid), .st_id(st_id),
    .spec_active(spec_active)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int olog [256]; int ocyc [256]; int o_n = 0;
  int slog [256]; int scyc [256]; int s_n = 0;

  always @(negedge clk) begin
    cyc++;
    if (out_valid && o_n < 256) begin
      olog[o_n] = {24'd0, out_replay, out_spec, out_cls, out_id};
      ocyc[o_n] = cyc; o_n++;
    end
    if (st_valid && s_n < 256) begin
      slog[s_n] = int'(st_id); scyc[s_n] = cyc; s_n++;
    end
  end

  function automatic int enc(input int rp, input int sp, input int c, input int id);
    return rp * 128 + sp * 64 + c * 16 + id;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input int c, input int id, input bit sp, input bit hit, output bit acc);
    @(negedge clk);
    in_valid = 1; in_cls = 2'(c); in_id = IDW'(id); in_spec = sp; in_hit = hit;
    #1 acc = in_ready;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 0;
    end
  endtask

  task automatic open_path(input int p);
    @(negedge clk); in_valid = 0; spec_req = 1; pred_prob = PW'(p);
    @(negedge clk); spec_req = 0;
  endtask

  task automatic resolve(input bit taken);
    @(negedge clk); in_valid = 0; res_valid = 1; res_taken = taken;
    #1 chk("R11 ready in resolve cycle", int'(in_ready), 0);
    @(negedge clk); res_valid = 0;
  endtask

  initial begin
    #1600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit a;
    int o0, s0;
    repeat (4) @(negedge clk);
    rst = 0;
    #1;
    // R12 reset state
    chk("R12 spec_active", int'(spec_active), 0);
    chk("R12 out_valid", int'(out_valid), 0);
    chk("R12 st_valid", int'(st_valid), 0);
    chk("R12 in_ready", int'(in_ready), 1);

    // R1 sweep of threshold against confidence
    for (int t = 0; t < 8; t++) begin
      for (int p = 0; p < 8; p++) begin
        cfg_thr = PW'(t);
        open_path(p);
        chk($sformatf("R1 thr=%0d prob=%0d", t, p), int'(spec_active), (p > t) ? 1 : 0);
        if (spec_active) resolve(1'b0);
      end
    end
    cfg_thr = 3'd3;

    // R2 no path open: tag ignored, everything forwarded unflagged
    o0 = o_n; s0 = s_n;
    issue(0, 1, 1, 0, a); issue(2, 2, 1, 0, a); issue(1, 3, 1, 0, a); issue(3, 4, 0, 0, a);
    idle(3);
    chk("R2 forward count", o_n - o0, 4);
    chk("R2 entry0", olog[o0], enc(0, 0, 0, 1));
    chk("R2 entry1", olog[o0+1], enc(0, 0, 2, 2));
    chk("R2 entry2", olog[o0+2], enc(0, 0, 1, 3));
    chk("R2 entry3", olog[o0+3], enc(0, 0, 3, 4));
    chk("R2 back-to-back", ocyc[o0+3] - ocyc[o0], 3);
    chk("R2 no store port", s_n - s0, 0);

    // Open path and issue a class mix
    open_path(6);
    chk("R1 open at 6>3", int'(spec_active), 1);
    o0 = o_n; s0 = s_n;
    issue(2, 1, 1, 0, a); issue(1, 2, 1, 1, a); issue(1, 3, 1, 0, a); issue(0, 4, 1, 0, a);
    issue(3, 5, 1, 0, a); issue(2, 6, 1, 0, a); issue(1, 7, 1, 0, a); issue(0, 8, 0, 0, a);
    idle(3);
    chk("R4 R5 forward count", o_n - o0, 3);
    chk("R4 load hit flagged", olog[o0], enc(0, 1, 1, 2));
    chk("R5 other flagged", olog[o0+1], enc(0, 1, 0, 4));
    chk("R2 untagged in path", olog[o0+2], enc(0, 0, 0, 8));
    chk("R3 no store out", s_n - s0, 0);
    o0 = o_n;
    resolve(1'b1);
    issue(0, 9, 0, 0, a);
    chk("R11 ready during drain", int'(a), 0);
    idle(8);
    chk("R6 replay count", o_n - o0, 3);
    chk("R6 replay0", olog[o0], enc(1, 0, 1, 3));
    chk("R6 replay1", olog[o0+1], enc(1, 0, 3, 5));
    chk("R6 replay2", olog[o0+2], enc(1, 0, 1, 7));
    chk("R6 one per cycle", ocyc[o0+2] - ocyc[o0], 2);
    chk("R7 store count", s_n - s0, 2);
    chk("R7 store0", slog[s0], 1);
    chk("R7 store1", slog[s0+1], 6);
    chk("R7 consecutive", scyc[s0+1] - scyc[s0], 1);
    chk("R7 parallel with replay", scyc[s0], ocyc[o0]);
    #1 chk("R11 ready after drain", int'(in_ready), 1);
    chk("R6 path closed", int'(spec_active), 0);

    // R8 squash
    open_path(7);
    o0 = o_n; s0 = s_n;
    issue(2, 9, 1, 0, a); issue(1, 10, 1, 0, a); issue(3, 11, 1, 0, a); issue(1, 12, 1, 1, a);
    resolve(1'b0);
    idle(8);
    chk("R8 only hit forwarded", o_n - o0, 1);
    chk("R8 hit entry", olog[o0], enc(0, 1, 1, 12));
    chk("R8 no stores", s_n - s0, 0);
    chk("R8 path closed", int'(spec_active), 0);

    // R9 R10 full buffers, capacity restored after squash
    open_path(5);
    o0 = o_n; s0 = s_n;
    for (int i = 0; i < SBD; i++) begin
      issue(2, i + 1, 1, 0, a);
      chk($sformatf("R8 R9 store %0d accepted", i), int'(a), 1);
    end
    issue(2, 13, 1, 0, a);
    chk("R9 store blocked when full", int'(a), 0);
    issue(0, 14, 1, 0, a);
    chk("R9 other still accepted", int'(a), 1);
    for (int i = 0; i < RQD; i++) begin
      issue(3, i + 5, 1, 0, a);
      chk($sformatf("R10 park %0d accepted", i), int'(a), 1);
    end
    issue(1, 15, 1, 0, a);
    chk("R10 miss blocked when full", int'(a), 0);
    idle(1);
    resolve(1'b1);
    idle(10);
    chk("R9 forward count", o_n - o0, 1 + RQD);
    chk("R9 other entry", olog[o0], enc(0, 1, 0, 14));
    for (int i = 0; i < RQD; i++)
      chk($sformatf("R10 replay %0d", i), olog[o0+1+i], enc(1, 0, 3, i + 5));
    chk("R7 full drain count", s_n - s0, SBD);
    for (int i = 0; i < SBD; i++)
      chk($sformatf("R7 store %0d order", i), slog[s0+i], i + 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule